// File: doc/BRIEF.md
# Masked Pattern-Match Interrupt Generator

This block watches an 8-bit port driven from an external bus whose timing is unrelated to the local clock. It reduces that port to one interrupt line. Each port bit first passes through a two-stage synchroniser. After that, every bit is checked on its own in one of three ways: it is ignored, it must sit at a programmed level, or it must show a programmed rising or falling change between two consecutive samples. All active bit terms are AND-ed into a single match condition. Because the condition is only ever evaluated on registered samples, a code that appears only between clock edges during a multi-bit change can never match.

Software-side logic programs the block through a small write port that holds four configuration words. It then enables recording and services the sticky interrupt flag with a clear pulse. A match is recorded once when the condition becomes true. Holding the same condition does not raise it again after a clear. The local clock is meant to run at an integer multiple of the roughly 3.5 MHz bus, so every bus state is sampled at least once.

Top module: `pattern_irq`

## Requirements
- R1: After reset `irq_o` is low, and all four configuration words read as zero in their effect on matching.
- R2: A bit whose care bit is 0 is ignored. With care word 0x7B and level word 0x71 (pattern ?1110?01, bit 7 first), port 0xF1 and port 0x75 match and port 0xF0 does not.
- R3: A bit whose care bit is 1 and whose edge-enable bit is 0 matches when the synchronised sample equals the corresponding bit of the level word.
- R4: A bit whose care bit and edge-enable bit are both 1 matches only on the cycle where the sample differs from the previous sample in the chosen direction: direction bit 1 selects 0-to-1, direction bit 0 selects 1-to-0. The level word is ignored for that bit.
- R5: Level terms and edge terms may be mixed, and the condition is true only when every cared bit's term is true in the same sample.
- R6: A port change applied before clock edge k sets `irq_o` after edge k+2, through two synchroniser stages and the flag register.
- R7: `irq_o` stays high until `clr_i` is sampled high, and then goes low after that edge. If a new match entry happens on the same edge as a clear, the flag stays set.
- R8: The flag is set only on the first cycle of a match condition. While the condition stays true, a clear is not undone.
- R9: While `en_i` is low, no match is recorded. A condition entered while disabled is not recorded when `en_i` rises during it.
- R10: A write with `cfg_we_i` high loads `cfg_data_i` into the word chosen by `cfg_addr_i` (0 care, 1 level, 2 edge enable, 3 direction). The new word applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 8 | Asynchronous bus bits being watched |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word select |
| cfg_data_i | input | 8 | Configuration write data |
| en_i | input | 1 | Enable for recording matches |
| clr_i | input | 1 | Interrupt clear pulse |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The assertions assume that `en_i`, `clr_i` and the configuration port are synchronous to `clk_i`. Only `port_i` is treated as asynchronous. The bench drives every input, the port included, on the falling edge, so all inputs are stable at each rising edge. The bench keeps its own cycle model of the sampling pipeline and of the flag. Random port traffic is biased towards the programmed pattern so that entries, exits and held matches all occur, alongside directed sequences for clears, disabled entries and edge directions.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    CFG_CARE  = 2'd0,
    CFG_LEVEL = 2'd1,
    CFG_EDGE  = 2'd2,
    CFG_DIR   = 2'd3
  } cfg_addr_e;
  localparam int unsigned CFG_WORDS = 4;
endpackage

// File: rtl/pm_cfg.sv
module pm_cfg
  import pm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] care_o,
  output logic [W-1:0] level_o,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] dir_o
);
  logic [CFG_WORDS-1:0][W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (we_i) begin
      for (int unsigned k = 0; k < CFG_WORDS; k++) begin
        if (addr_i == 2'(k)) word_q[k] <= data_i;
      end
    end
  end

  assign care_o  = word_q[CFG_CARE];
  assign level_o = word_q[CFG_LEVEL];
  assign edge_o  = word_q[CFG_EDGE];
  assign dir_o   = word_q[CFG_DIR];

  // R10
  care_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CFG_CARE) |=> care_o == $past(data_i));
  // R10
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(care_o) && $stable(level_o) && $stable(edge_o) && $stable(dir_o)));
endmodule

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int unsigned s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];

  // R6
  stage_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_o == $past(st_q[STAGES-2]));
endmodule

// File: rtl/pm_match.sv
module pm_match #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] care_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] dir_i,
  output logic         hit_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= smp_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_term
    always_comb begin
      if (!care_i[b])      term[b] = 1'b1;
      else if (edge_i[b])  term[b] = dir_i[b] ? (smp_i[b] & ~prev_q[b])
                                              : (~smp_i[b] & prev_q[b]);
      else                 term[b] = (smp_i[b] == level_i[b]);
    end
  end

  assign hit_o = &term;

  // R4
  edge_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && |(care_i & edge_i)) |-> ((smp_i ^ prev_q) & care_i & edge_i) == (care_i & edge_i));
  // R2
  idle_care_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (care_i == '0) |-> hit_o);
endmodule

// File: rtl/pm_flag.sv
module pm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic hit_i,
  output logic irq_o
);
  logic hit_q;
  logic flag_q;
  logic entry;

  assign entry = en_i & hit_i & ~hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q <= hit_i;
      if (entry)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign irq_o = flag_q;

  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  // R9
  gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !flag_q) |=> !flag_q);
  // R8
  first_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(hit_i) && !$past(hit_q)));
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !flag_q);
endmodule

// File: rtl/pattern_irq.sv
module pattern_irq #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] port_i,
  input  logic         cfg_we_i,
  input  logic [1:0]   cfg_addr_i,
  input  logic [W-1:0] cfg_data_i,
  input  logic         en_i,
  input  logic         clr_i,
  output logic         irq_o
);
  logic [W-1:0] care, level, edg, dir;
  logic [W-1:0] smp;
  logic         hit;

  pm_cfg #(.W(W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .care_o (care),
    .level_o(level),
    .edge_o (edg),
    .dir_o  (dir)
  );

  pm_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_i),
    .q_o   (smp)
  );

  pm_match #(.W(W)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp),
    .care_i (care),
    .level_i(level),
    .edge_i (edg),
    .dir_i  (dir),
    .hit_o  (hit)
  );

  pm_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .clr_i (clr_i),
    .hit_i (hit),
    .irq_o (irq_o)
  );

  // R3
  level_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> ((smp ^ level) & care & ~edg) == '0);
endmodule

// File: tb/sim_pattern_irq.sv
module sim_pattern_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic       en = 1'b0;
  logic       clr = 1'b0;
  logic       irq;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // model state
  logic [7:0] m1, m2, mp, mc, ml, me, md;
  logic       mq, mf;

  pattern_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .port_i(port), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_data_i(data), .en_i(en), .clr_i(clr), .irq_o(irq)
  );

  always #5 clk = ~clk;

  function automatic logic cond_f(logic [7:0] cur, logic [7:0] prv, logic [7:0] c,
                                  logic [7:0] l, logic [7:0] e, logic [7:0] d);
    logic ok = 1'b1;
    for (int b = 0; b < 8; b++) begin
      if (c[b]) begin
        if (e[b]) ok &= d[b] ? (cur[b] && !prv[b]) : (!cur[b] && prv[b]);
        else      ok &= (cur[b] == l[b]);
      end
    end
    return ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = '0; m2 = '0; mp = '0; mc = '0; ml = '0; me = '0; md = '0; mq = 0; mf = 0;
    end else begin
      logic c;
      c = cond_f(m2, mp, mc, ml, me, md);
      if (en && c && !mq) mf = 1'b1;
      else if (clr)       mf = 1'b0;
      mq = c; mp = m2; m2 = m1; m1 = port;
      if (we) case (addr)
        2'd0: mc = data;
        2'd1: ml = data;
        2'd2: me = data;
        default: md = data;
      endcase
    end
  end

  task automatic check(string t, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: irq_o=%0b expected %0b at %0t", t, act, exp, $time);
    end
  endtask

  // one cycle, then compare with model
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(tag, irq, mf);
    we = 1'b0;
    clr = 1'b0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1'b1; addr = a; data = d;
    step();
  endtask

  task automatic clear();
    clr = 1'b1;
    step();
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    step();
    check("R1 reset", irq, 1'b0);
    steps(3);
    check("R1 idle", irq, 1'b0);

    // R10: program pattern ?1110?01
    tag = "R10";
    wr(2'd0, 8'h7B);
    wr(2'd1, 8'h71);
    port = 8'hF0;
    en = 1'b1;
    steps(5);
    tag = "R2";
    check("R2 F0 no match", irq, 1'b0);

    // R6 latency
    port = 8'hF1;
    tag = "R6";
    steps(2);
    check("R6 not yet", irq, 1'b0);
    step();
    check("R6 set after third edge", irq, 1'b1);

    // R7 sticky through exit
    tag = "R7";
    port = 8'hF0;
    steps(6);
    check("R7 sticky", irq, 1'b1);
    clear();
    check("R7 cleared", irq, 1'b0);

    // R2 don't-care bits
    tag = "R2";
    port = 8'h75;
    steps(4);
    check("R2 0x75 match", irq, 1'b1);

    // R8 held condition does not re-arm after clear
    tag = "R8";
    clear();
    steps(6);
    check("R8 no re-set while held", irq, 1'b0);

    // R9 entry while disabled
    tag = "R9";
    port = 8'hF0;
    steps(3);
    en = 1'b0;
    port = 8'hF1;
    steps(5);
    check("R9 disabled", irq, 1'b0);
    en = 1'b1;
    steps(4);
    check("R9 held entry not recorded", irq, 1'b0);
    port = 8'hF0;
    steps(3);
    port = 8'hF1;
    steps(4);
    check("R9 new entry recorded", irq, 1'b1);

    // R7 set wins over clear on same edge
    tag = "R7";
    clear();
    port = 8'hF0;
    steps(4);
    port = 8'hF1;
    steps(2);
    clr = 1'b1;
    step();
    check("R7 set beats clear", irq, 1'b1);
    clear();

    // R4 edge terms on bit 0
    tag = "R4";
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h00);
    port = 8'h01;
    steps(4);
    clear();
    check("R4 cleared", irq, 1'b0);
    port = 8'h00;
    steps(4);
    check("R4 falling ignored for rise", irq, 1'b0);
    port = 8'h01;
    steps(3);
    check("R4 rise", irq, 1'b1);
    clear();
    wr(2'd3, 8'h00);
    steps(3);
    check("R4 no fall yet", irq, 1'b0);
    port = 8'h00;
    steps(3);
    check("R4 fall", irq, 1'b1);
    clear();

    // R5 mixed: bit1 level 1, bit0 rising
    tag = "R5";
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h02);
    wr(2'd3, 8'h01);
    port = 8'h00;
    steps(3);
    clear();
    port = 8'h01;
    steps(4);
    check("R5 edge without level", irq, 1'b0);
    port = 8'h02;
    steps(4);
    check("R5 level without edge", irq, 1'b0);
    port = 8'h03;
    steps(3);
    check("R5 both", irq, 1'b1);
    clear();

    // R3 random traffic against model
    tag = "R3";
    wr(2'd0, 8'h7B);
    wr(2'd1, 8'h71);
    wr(2'd2, 8'h00);
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 2) begin
        we = 1'b1;
        addr = 2'($urandom_range(0, 3));
        data = 8'($urandom);
      end
      if (r >= 2 && r < 8) clr = 1'b1;
      if (r >= 8 && r < 10) en = ~en;
      if ($urandom_range(0, 1) == 0) port = 8'h71 | (8'($urandom) & 8'h84);
      else                           port = 8'($urandom);
      step();
    end
    finish_up();
  end
endmodule